// File: doc/BRIEF.md
# Endpoint Interrupt Status Latch

This block turns per-endpoint transfer events from a USB device engine into latched interrupt request bits. Each event names an endpoint, its direction, its transfer type, and whether the packet succeeded or a NAK handshake went out. The block decides from these fields whether the event deserves an interrupt and sets that endpoint's bit. Isochronous endpoints are handled differently: their per-packet events are dropped, and a periodic 1 ms frame pulse sets the bit of every endpoint marked isochronous instead.

A second 32-bit bank records bus errors raised by the DMA engine while it moves an endpoint's data or fetches or writes back its descriptor. Only endpoints 2 and up can own such a bit. Both banks have a read-only status view and write-one set and clear ports. Each bank drives one registered interrupt line, formed from its status bits under a per-bit enable mask.

Top module: `usb_ep_irq_status`

## Requirements
- R1: After reset, both status banks and both interrupt outputs are 0.
- R2: An event on an enabled endpoint whose type is not isochronous and whose direction is OUT (`ev_dir_in`=0) sets that endpoint's transfer bit only when `ev_ok`=1 and `ev_nak`=0. An errored packet (`ev_ok`=0) or a NAK leaves every bit unchanged.
- R3: An event on an enabled endpoint whose type is not isochronous and whose direction is IN (`ev_dir_in`=1) sets that endpoint's transfer bit when `ev_ok`=1.
- R4: An IN event with `ev_nak`=1 on an enabled endpoint whose type is not isochronous sets the bit only while `nak_irq_en`=1.
- R5: Events with type code 1 (isochronous) never set a bit. Type codes are 0 control, 1 isochronous, 2 bulk and 3 interrupt. A `frame_tick` pulse sets every transfer bit i for which both `iso_map[i]` and `ep_en[i]` are 1.
- R6: An event on an endpoint whose `ep_en` bit is 0 changes no bit in either bank.
- R7: An error event (`err_valid`) on an enabled endpoint 2 to 31 sets that endpoint's error bit. Error bits 0 and 1 always read 0, and set writes to them have no effect.
- R8: In either bank, writing 1 to a clear-port bit clears that status bit. Clear-port bits written as 0 leave their status bits unchanged.
- R9: In either bank, writing 1 to a set-port bit sets that status bit. Set-port bits written as 0 leave their status bits unchanged.
- R10: When a set (hardware event or set port) and a clear hit the same bit in the same cycle, the bit ends set.
- R11: Each interrupt output is high exactly when its bank had any status bit AND its mask bit set one cycle earlier. The output updates one clock after the status bit it reflects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_valid | input | 1 | Transfer event strobe |
| ev_ep | input | 5 | Endpoint number of the event |
| ev_dir_in | input | 1 | 1 = IN (to host), 0 = OUT |
| ev_type | input | 2 | 0 control, 1 isochronous, 2 bulk, 3 interrupt |
| ev_ok | input | 1 | Packet completed without error |
| ev_nak | input | 1 | NAK handshake was sent |
| nak_irq_en | input | 1 | Allow NAK-triggered IN interrupts |
| frame_tick | input | 1 | 1 ms frame pulse |
| iso_map | input | 32 | Endpoints configured as isochronous |
| ep_en | input | 32 | Per-endpoint enable |
| xfer_set_wr | input | 32 | Write-one set port, transfer bank |
| xfer_clr_wr | input | 32 | Write-one clear port, transfer bank |
| xfer_irq_mask | input | 32 | Interrupt enable mask, transfer bank |
| xfer_stat | output | 32 | Transfer status view |
| xfer_irq | output | 1 | Transfer bank interrupt |
| err_valid | input | 1 | DMA bus error strobe |
| err_ep | input | 5 | Endpoint of the bus error |
| err_set_wr | input | 32 | Write-one set port, error bank |
| err_clr_wr | input | 32 | Write-one clear port, error bank |
| err_irq_mask | input | 32 | Interrupt enable mask, error bank |
| err_stat | output | 32 | Error status view |
| err_irq | output | 1 | Error bank interrupt |

## Verification
The bench builds the block with its default 32 endpoints and a first error-capable endpoint of 2, the full width the register view needs. At that size every endpoint number can be crossed with both directions, all four type codes, each ok/NAK combination, both NAK-mode settings and two enable patterns. That reaches every qualification path of every bit, including the two reserved error bits. Directed cycles then cover same-cycle set/clear collisions and the one-cycle lag of the interrupt lines under chosen masks.

// File: rtl/usb_ep_irq_pkg.sv
// Shared types for the endpoint interrupt status block.
// Assumes the 2-bit transfer type coding used on the event port.
package usb_ep_irq_pkg;
    typedef enum logic [1:0] {
        XT_CONTROL = 2'd0,
        XT_ISO     = 2'd1,
        XT_BULK    = 2'd2,
        XT_INTR    = 2'd3
    } xfer_kind_e;
endpackage

// File: rtl/ep_event_qualify.sv
// Decodes one transfer event plus the frame pulse into a per-endpoint
// set vector. Assumes at most one event per cycle. Output is combinational.
module ep_event_qualify
    import usb_ep_irq_pkg::*;
#(
    parameter int NUM_EP = 32,
    localparam int EP_W  = $clog2(NUM_EP)
) (
    input  logic              ev_valid,
    input  logic [EP_W-1:0]   ev_ep,
    input  logic              ev_dir_in,
    input  logic [1:0]        ev_type,
    input  logic              ev_ok,
    input  logic              ev_nak,
    input  logic              nak_irq_en,
    input  logic              frame_tick,
    input  logic [NUM_EP-1:0] iso_map,
    input  logic [NUM_EP-1:0] ep_en,
    output logic [NUM_EP-1:0] set_vec
);
    xfer_kind_e kind;
    logic       worth_irq;

    // Decide whether the event deserves an interrupt, ignoring endpoint.
    always_comb begin
        kind      = xfer_kind_e'(ev_type);
        worth_irq = 1'b0;
        if (ev_valid && kind != XT_ISO) begin
            if (ev_dir_in)
                worth_irq = ev_ok || (ev_nak && nak_irq_en);
            else
                worth_irq = ev_ok && !ev_nak;
        end
    end

    // One set line per endpoint: addressed event or frame pulse, gated by enable.
    for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
        assign set_vec[i] = ep_en[i] &&
            ((worth_irq && ev_ep == EP_W'(i)) || (frame_tick && iso_map[i]));
    end
endmodule

// File: rtl/ep_err_decode.sv
// Turns a DMA bus-error strobe into a one-hot set vector for the error bank.
// Assumes the endpoint number is valid whenever the strobe is high.
module ep_err_decode #(
    parameter int NUM_EP = 32,
    localparam int EP_W  = $clog2(NUM_EP)
) (
    input  logic              err_valid,
    input  logic [EP_W-1:0]   err_ep,
    input  logic [NUM_EP-1:0] ep_en,
    output logic [NUM_EP-1:0] set_vec
);
    // Decode the error endpoint, gated by its enable.
    for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
        assign set_vec[i] = err_valid && ep_en[i] && err_ep == EP_W'(i);
    end
endmodule

// File: rtl/irq_status_bank.sv
// One latched status bank with write-one set/clear and a registered,
// masked interrupt. Bits below RSVD_LOW are tied to 0. A set beats a
// clear on the same bit in the same cycle.
module irq_status_bank #(
    parameter int WIDTH    = 32,
    parameter int RSVD_LOW = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] hw_set,
    input  logic [WIDTH-1:0] sw_set,
    input  logic [WIDTH-1:0] sw_clr,
    input  logic [WIDTH-1:0] mask,
    output logic [WIDTH-1:0] stat,
    output logic             irq
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i < RSVD_LOW) begin : g_rsvd
            assign stat[i] = 1'b0;
        end else begin : g_live
            logic bit_q;
            // Hold the status bit; sets take priority over clears.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    bit_q <= 1'b0;
                else if (hw_set[i] || sw_set[i])
                    bit_q <= 1'b1;
                else if (sw_clr[i])
                    bit_q <= 1'b0;
            end
            assign stat[i] = bit_q;
        end
    end

    // Register the masked OR of the current status.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else
            irq <= |(stat & mask);
    end
endmodule

// File: rtl/usb_ep_irq_status.sv
// Endpoint interrupt status top: a transfer bank fed by qualified endpoint
// events and frame pulses, and an error bank fed by DMA bus errors.
// Assumes single-cycle event strobes and synchronous inputs.
module usb_ep_irq_status #(
    parameter int NUM_EP       = 32,
    parameter int FIRST_ERR_EP = 2,
    localparam int EP_W        = $clog2(NUM_EP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic [EP_W-1:0]   ev_ep,
    input  logic              ev_dir_in,
    input  logic [1:0]        ev_type,
    input  logic              ev_ok,
    input  logic              ev_nak,
    input  logic              nak_irq_en,
    input  logic              frame_tick,
    input  logic [NUM_EP-1:0] iso_map,
    input  logic [NUM_EP-1:0] ep_en,
    input  logic [NUM_EP-1:0] xfer_set_wr,
    input  logic [NUM_EP-1:0] xfer_clr_wr,
    input  logic [NUM_EP-1:0] xfer_irq_mask,
    output logic [NUM_EP-1:0] xfer_stat,
    output logic              xfer_irq,
    input  logic              err_valid,
    input  logic [EP_W-1:0]   err_ep,
    input  logic [NUM_EP-1:0] err_set_wr,
    input  logic [NUM_EP-1:0] err_clr_wr,
    input  logic [NUM_EP-1:0] err_irq_mask,
    output logic [NUM_EP-1:0] err_stat,
    output logic              err_irq
);
    logic [NUM_EP-1:0] xfer_hw_set;
    logic [NUM_EP-1:0] err_hw_set;

    ep_event_qualify #(.NUM_EP(NUM_EP)) u_qual (
        .ev_valid   (ev_valid),
        .ev_ep      (ev_ep),
        .ev_dir_in  (ev_dir_in),
        .ev_type    (ev_type),
        .ev_ok      (ev_ok),
        .ev_nak     (ev_nak),
        .nak_irq_en (nak_irq_en),
        .frame_tick (frame_tick),
        .iso_map    (iso_map),
        .ep_en      (ep_en),
        .set_vec    (xfer_hw_set)
    );

    ep_err_decode #(.NUM_EP(NUM_EP)) u_errdec (
        .err_valid (err_valid),
        .err_ep    (err_ep),
        .ep_en     (ep_en),
        .set_vec   (err_hw_set)
    );

    irq_status_bank #(.WIDTH(NUM_EP), .RSVD_LOW(0)) u_xfer_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .hw_set (xfer_hw_set),
        .sw_set (xfer_set_wr),
        .sw_clr (xfer_clr_wr),
        .mask   (xfer_irq_mask),
        .stat   (xfer_stat),
        .irq    (xfer_irq)
    );

    irq_status_bank #(.WIDTH(NUM_EP), .RSVD_LOW(FIRST_ERR_EP)) u_err_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .hw_set (err_hw_set),
        .sw_set (err_set_wr),
        .sw_clr (err_clr_wr),
        .mask   (err_irq_mask),
        .stat   (err_stat),
        .irq    (err_irq)
    );
endmodule

// File: rtl/usb_ep_irq_status_chk.sv
// Property checker for usb_ep_irq_status, attached by bind below.
module usb_ep_irq_status_chk #(
    parameter int NUM_EP = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ev_valid,
    input logic              frame_tick,
    input logic              err_valid,
    input logic [NUM_EP-1:0] xfer_set_wr,
    input logic [NUM_EP-1:0] xfer_clr_wr,
    input logic [NUM_EP-1:0] xfer_irq_mask,
    input logic [NUM_EP-1:0] xfer_stat,
    input logic              xfer_irq,
    input logic [NUM_EP-1:0] err_set_wr,
    input logic [NUM_EP-1:0] err_clr_wr,
    input logic [NUM_EP-1:0] err_stat
);
    // R7: reserved error bits never read 1
    a_r7_err_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        err_stat[1:0] == 2'b00);

    // R9: software set lands one cycle later
    a_r9_xfer_set: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_set_wr != '0) |=> ((xfer_stat & $past(xfer_set_wr)) == $past(xfer_set_wr)));

    // R9: software set in the error bank, outside reserved bits
    a_r9_err_set: assert property (@(posedge clk) disable iff (!rst_n)
        (err_set_wr != '0) |=> ((err_stat & $past(err_set_wr) & ~NUM_EP'(3))
                                == ($past(err_set_wr) & ~NUM_EP'(3))));

    // R8: clear with no competing source empties the written bits
    a_r8_xfer_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_clr_wr != '0 && xfer_set_wr == '0 && !ev_valid && !frame_tick)
        |=> ((xfer_stat & $past(xfer_clr_wr)) == '0));

    // R8: clear in the error bank
    a_r8_err_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr_wr != '0 && err_set_wr == '0 && !err_valid)
        |=> ((err_stat & $past(err_clr_wr)) == '0));

    // R6: with no activity at all the transfer bank holds
    a_r6_xfer_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_valid && !frame_tick && xfer_set_wr == '0 && xfer_clr_wr == '0)
        |=> $stable(xfer_stat));

    // R11: interrupt line follows last cycle's masked status
    a_r11_xfer_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (xfer_irq == ($past(xfer_stat & xfer_irq_mask) != '0)));
endmodule

bind usb_ep_irq_status usb_ep_irq_status_chk #(.NUM_EP(NUM_EP)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ev_valid      (ev_valid),
    .frame_tick    (frame_tick),
    .err_valid     (err_valid),
    .xfer_set_wr   (xfer_set_wr),
    .xfer_clr_wr   (xfer_clr_wr),
    .xfer_irq_mask (xfer_irq_mask),
    .xfer_stat     (xfer_stat),
    .xfer_irq      (xfer_irq),
    .err_set_wr    (err_set_wr),
    .err_clr_wr    (err_clr_wr),
    .err_stat      (err_stat)
);

// File: tb/usb_ep_irq_status_tb_top.sv
// Sweep bench: every endpoint, direction, type, ok/NAK combination and mode.
module usb_ep_irq_status_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_valid = 0, ev_dir_in = 0, ev_ok = 0, ev_nak = 0;
    logic [4:0]  ev_ep = '0, err_ep = '0;
    logic [1:0]  ev_type = '0;
    logic        nak_irq_en = 0, frame_tick = 0, err_valid = 0;
    logic [31:0] iso_map = '0, ep_en = '0;
    logic [31:0] xfer_set_wr = '0, xfer_clr_wr = '0, xfer_irq_mask = '0;
    logic [31:0] err_set_wr = '0, err_clr_wr = '0, err_irq_mask = '0;
    logic [31:0] xfer_stat, err_stat;
    logic        xfer_irq, err_irq;
    int checks = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    usb_ep_irq_status dut_i (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_all();
        @(negedge clk);
        xfer_clr_wr = '1; err_clr_wr = '1;
        @(negedge clk);
        xfer_clr_wr = '0; err_clr_wr = '0;
    endtask

    function automatic logic exp_hit(input logic en, input logic [1:0] ty, input logic din,
                                     input logic ok, input logic nak, input logic nen);
        if (!en || ty == 2'd1) return 1'b0;
        if (din) return ok || (nak && nen);
        return ok && !nak;
    endfunction

    function automatic string tag(input logic en, input logic [1:0] ty, input logic din,
                                  input logic nak);
        if (!en) return "R6";
        if (ty == 2'd1) return "R5";
        if (!din) return "R2";
        if (nak) return "R4";
        return "R3";
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 xfer_stat", xfer_stat, '0);
        chk("R1 err_stat", err_stat, '0);
        chk("R1 irqs", {30'd0, xfer_irq, err_irq}, '0);
        rst_n = 1'b1;

        // Event sweep over two enable patterns.
        for (int pass = 0; pass < 2; pass++) begin
            ep_en = (pass == 0) ? 32'hFFFF_FFFF : 32'hA5A5_5A5A;
            for (int ep = 0; ep < 32; ep++)
                for (int ty = 0; ty < 4; ty++)
                    for (int c = 0; c < 16; c++) begin
                        logic din, ok, nak, nen, e;
                        din = c[0]; ok = c[1]; nak = c[2]; nen = c[3];
                        @(negedge clk);
                        ev_valid = 1; ev_ep = 5'(ep); ev_type = 2'(ty);
                        ev_dir_in = din; ev_ok = ok; ev_nak = nak; nak_irq_en = nen;
                        @(negedge clk);
                        ev_valid = 0;
                        e = exp_hit(ep_en[ep], 2'(ty), din, ok, nak, nen);
                        chk(tag(ep_en[ep], 2'(ty), din, nak), xfer_stat,
                            e ? (32'd1 << ep) : 32'd0);
                        clear_all();
                    end
        end

        // Frame pulse.
        iso_map = 32'h0000_F00F; ep_en = 32'hFF00_FF0F;
        @(negedge clk); frame_tick = 1;
        @(negedge clk); frame_tick = 0;
        chk("R5 frame", xfer_stat, 32'h0000_F00F & 32'hFF00_FF0F);
        clear_all();

        // Error sweep.
        for (int pass = 0; pass < 2; pass++) begin
            ep_en = (pass == 0) ? 32'hFFFF_FFFF : 32'h3C3C_C3C3;
            for (int ep = 0; ep < 32; ep++) begin
                @(negedge clk); err_valid = 1; err_ep = 5'(ep);
                @(negedge clk); err_valid = 0;
                chk(ep_en[ep] ? "R7 err" : "R6 err", err_stat,
                    (ep_en[ep] && ep >= 2) ? (32'd1 << ep) : 32'd0);
                clear_all();
            end
        end
        ep_en = '1;

        // Set ports, then partial and null clears.
        @(negedge clk); xfer_set_wr = '1; err_set_wr = '1;
        @(negedge clk); xfer_set_wr = '0; err_set_wr = '0;
        chk("R9 xfer set", xfer_stat, 32'hFFFF_FFFF);
        chk("R9/R7 err set", err_stat, 32'hFFFF_FFFC);
        xfer_clr_wr = 32'h0F0F_0F0F; err_clr_wr = 32'h0000_FFFF;
        @(negedge clk); xfer_clr_wr = '0; err_clr_wr = '0;
        chk("R8 xfer clr", xfer_stat, 32'hF0F0_F0F0);
        chk("R8 err clr", err_stat, 32'hFFFF_0000);
        @(negedge clk);
        chk("R8 zero clr", xfer_stat, 32'hF0F0_F0F0);
        clear_all();

        // Same-cycle set and clear.
        @(negedge clk);
        xfer_clr_wr = '1; err_clr_wr = '1; xfer_set_wr = 32'h20;
        ev_valid = 1; ev_ep = 5'd9; ev_type = 2'd2; ev_dir_in = 0; ev_ok = 1; ev_nak = 0;
        err_valid = 1; err_ep = 5'd7;
        @(negedge clk);
        xfer_clr_wr = '0; err_clr_wr = '0; xfer_set_wr = '0; ev_valid = 0; err_valid = 0;
        chk("R10 xfer", xfer_stat, 32'h0000_0220);
        chk("R10 err", err_stat, 32'h0000_0080);

        // Interrupt registration and masking.
        xfer_irq_mask = 32'h200; err_irq_mask = 32'h100;
        @(negedge clk);
        chk("R11 masked", {30'd0, xfer_irq, err_irq}, 32'b10);
        clear_all();
        @(negedge clk);
        chk("R11 after clear", {31'd0, xfer_irq}, 32'd0);
        err_set_wr = 32'h100;
        @(negedge clk); err_set_wr = '0;
        chk("R11 lag", {31'd0, err_irq}, 32'd0);
        @(negedge clk);
        chk("R11 rise", {31'd0, err_irq}, 32'd1);

        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule